// File: doc/BRIEF.md
# Fault Flag and Interrupt Aggregator

This block gathers fault levels from a supply monitor and from two driver groups, a high-side group and a low-side group of two channels each. It keeps every fault in a sticky status register that software clears by reading. It drives an active-low interrupt line together with a 4-bit source code that names the fault class behind the interrupt. It also applies the shutdown and re-enable rules of each class to the driver enable outputs.

Each class has its own rule. A driver group that overheats is switched off and shows every flag of its register. An over-voltage on the supply switches both groups off when high-voltage shutdown is enabled and the device is in Normal mode. An over-current leaves the driver running in limited mode and only raises a flag. A group that has been switched off comes back only when software writes its control register after the cause has gone. Interrupts are raised only in the three active operating modes, and a masked source never raises one.

Top module: `fault_irq_hub`

## Requirements
- R1: The supply status register `sup_stat_o` holds battery fail in bit 0, regulator over-temperature warning in bit 1, supply under-voltage in bit 2 and supply over-voltage in bit 3. A bit is set one clock after its input level is sampled high.
- R2: `hs_stat_o` and `ls_stat_o` both use the same layout: channel 0 current limit in bit 0, channel 0 open load in bit 1, channel 1 current limit in bit 2 and channel 1 open load in bit 3.
- R3: A group over-temperature input sets all four bits of that group's status register and forces both enables of that group to 0 on the next clock. A control write made while the over-temperature is still present is ignored. It does not affect the other group.
- R4: Supply over-voltage with `hvse_i`=1 in mode 0 (Normal) forces both driver groups off on the next clock. The same over-voltage in any other mode, or with `hvse_i`=0, leaves the enables unchanged.
- R5: A current-limit or open-load input does not change a driver enable.
- R6: Status bits are sticky. A read strobe clears the register on the next clock, except for the bits whose condition is present in the same cycle, which stay set.
- R7: A pending high-side source reports code 0010, a pending low-side source reports code 0011, and a pending supply source (under- or over-voltage) reports code 0101. While any source is pending, `irq_n_o` is 0. With nothing pending, the code is 0000 and `irq_n_o` is 1.
- R8: When several sources are pending, the one with the lowest code is reported. A source stops pending when its status register is read with its condition gone. `irq_n_o` returns to 1 once every pending source has been read.
- R9: Sources become pending only when `mode_i` is 0 (Normal), 1 (Normal Request) or 2 (Stop). In mode 3 (low power) the status bits still latch, but no interrupt is raised.
- R10: A source whose mask input is 1 does not become pending. Its status bits still latch.
- R11: A write strobe to a group control register loads the written value into that group's enables when no shutdown condition for the group is present in that cycle.
- R12: After reset, all status registers are 0, the code is 0000, `irq_n_o` is 1 and all driver enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode: 0 Normal, 1 Normal Request, 2 Stop, 3 low power |
| hvse_i | input | 1 | High-voltage shutdown enable |
| sup_bf_i | input | 1 | Battery-fail level |
| sup_otw_i | input | 1 | Regulator over-temperature warning level |
| sup_uv_i | input | 1 | Supply under-voltage level |
| sup_ov_i | input | 1 | Supply over-voltage level |
| hs_ot_i | input | 1 | High-side group over-temperature |
| hs_cl_i | input | 2 | High-side current limit, per channel |
| hs_ol_i | input | 2 | High-side open load, per channel |
| ls_ot_i | input | 1 | Low-side group over-temperature |
| ls_cl_i | input | 2 | Low-side current limit, per channel |
| ls_ol_i | input | 2 | Low-side open load, per channel |
| mask_sup_i | input | 1 | Mask for the supply interrupt source |
| mask_hs_i | input | 1 | Mask for the high-side interrupt source |
| mask_ls_i | input | 1 | Mask for the low-side interrupt source |
| rd_sup_i | input | 1 | Read strobe, supply status register |
| rd_hs_i | input | 1 | Read strobe, high-side status register |
| rd_ls_i | input | 1 | Read strobe, low-side status register |
| wr_hs_i | input | 1 | Write strobe, high-side control register |
| wr_hs_d_i | input | 2 | High-side enables to write |
| wr_ls_i | input | 1 | Write strobe, low-side control register |
| wr_ls_d_i | input | 2 | Low-side enables to write |
| sup_stat_o | output | 4 | Supply status register |
| hs_stat_o | output | 4 | High-side status register |
| ls_stat_o | output | 4 | Low-side status register |
| isr_code_o | output | 4 | Interrupt source code |
| irq_n_o | output | 1 | Active-low interrupt |
| hs_en_o | output | 2 | High-side driver enables |
| ls_en_o | output | 2 | Low-side driver enables |

## Verification
Every result of the block comes from a single register stage. Status bits, pending sources and enables all reflect inputs sampled at a clock edge, and the values appear right after that edge. The code and `irq_n_o` are decoded from the pending register without further delay. Each check therefore applies the stimulus on a falling edge, waits for exactly one rising edge, and samples on the following falling edge. The bench model advances once on that same rising edge, so actual and expected values always refer to the same cycle.

// File: rtl/fih_pkg.sv
package fih_pkg;

    localparam int DRV_N  = 2;
    localparam int STAT_W = 2 * DRV_N;
    localparam int CODE_W = 4;
    localparam int SRC_N  = 3;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_NREQ   = 2'd1,
        MODE_STOP   = 2'd2,
        MODE_QUIET  = 2'd3
    } op_mode_e;

    // source index order must follow ascending code order (arbiter relies on it)
    typedef enum int {
        SRC_HS  = 0,
        SRC_LS  = 1,
        SRC_SUP = 2
    } src_idx_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 4'b0000;
    localparam logic [CODE_W-1:0] CODE_HS   = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_LS   = 4'b0011;
    localparam logic [CODE_W-1:0] CODE_SUP  = 4'b0101;

    typedef struct packed {
        logic ov;
        logic uv;
        logic otw;
        logic bf;
    } sup_fault_t;

    typedef struct packed {
        logic             ot;
        logic [DRV_N-1:0] cl;
        logic [DRV_N-1:0] ol;
    } drv_fault_t;

    function automatic logic [STAT_W-1:0] drv_stat(drv_fault_t f);
        logic [STAT_W-1:0] s;
        for (int i = 0; i < DRV_N; i++) begin
            s[2*i]   = f.cl[i];
            s[2*i+1] = f.ol[i];
        end
        if (f.ot) s = '1;
        return s;
    endfunction

    function automatic logic drv_any(drv_fault_t f);
        return f.ot | (|f.cl) | (|f.ol);
    endfunction

    function automatic logic irq_mode_ok(op_mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_NREQ) || (m == MODE_STOP);
    endfunction

    function automatic logic [CODE_W-1:0] src_code(int idx);
        case (idx)
            SRC_HS:  return CODE_HS;
            SRC_LS:  return CODE_LS;
            SRC_SUP: return CODE_SUP;
            default: return CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fih_sticky_reg.sv
module fih_sticky_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    output logic [W-1:0] q_o
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                end else begin
                    // a present condition wins over the clearing read
                    flag_q <= (flag_q & ~rd_i) | set_i[b];
                end
            end
            assign q_o[b] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/fih_drv_gate.sv
module fih_drv_gate #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shut_i,
    input  logic         wr_i,
    input  logic [N-1:0] wr_d_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (shut_i) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q <= wr_d_i;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/fih_irq_arb.sv
module fih_irq_arb
    import fih_pkg::*;
#(
    parameter int NSRC = SRC_N,
    parameter int CW   = CODE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            allow_i,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [CW-1:0]   code_o,
    output logic            irq_n_o
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] arm;

    assign arm = req_i & ~mask_i & {NSRC{allow_i}};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | arm;
        end
    end

    // lowest index carries the lowest code, so it is taken last and wins
    always_comb begin
        code_o = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_q[i]) code_o = src_code(i);
        end
    end

    assign irq_n_o = ~(|pend_q);

endmodule

// File: rtl/fault_irq_hub.sv
module fault_irq_hub
    import fih_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              hvse_i,
    input  logic              sup_bf_i,
    input  logic              sup_otw_i,
    input  logic              sup_uv_i,
    input  logic              sup_ov_i,
    input  logic              hs_ot_i,
    input  logic [DRV_N-1:0]  hs_cl_i,
    input  logic [DRV_N-1:0]  hs_ol_i,
    input  logic              ls_ot_i,
    input  logic [DRV_N-1:0]  ls_cl_i,
    input  logic [DRV_N-1:0]  ls_ol_i,
    input  logic              mask_sup_i,
    input  logic              mask_hs_i,
    input  logic              mask_ls_i,
    input  logic              rd_sup_i,
    input  logic              rd_hs_i,
    input  logic              rd_ls_i,
    input  logic              wr_hs_i,
    input  logic [DRV_N-1:0]  wr_hs_d_i,
    input  logic              wr_ls_i,
    input  logic [DRV_N-1:0]  wr_ls_d_i,
    output logic [3:0]        sup_stat_o,
    output logic [STAT_W-1:0] hs_stat_o,
    output logic [STAT_W-1:0] ls_stat_o,
    output logic [CODE_W-1:0] isr_code_o,
    output logic              irq_n_o,
    output logic [DRV_N-1:0]  hs_en_o,
    output logic [DRV_N-1:0]  ls_en_o
);

    op_mode_e   mode;
    sup_fault_t sup_f;
    drv_fault_t hs_f;
    drv_fault_t ls_f;
    logic       ov_shut;
    logic [SRC_N-1:0] req, mask, clr;

    assign mode  = op_mode_e'(mode_i);
    assign sup_f = '{ov: sup_ov_i, uv: sup_uv_i, otw: sup_otw_i, bf: sup_bf_i};
    assign hs_f  = '{ot: hs_ot_i, cl: hs_cl_i, ol: hs_ol_i};
    assign ls_f  = '{ot: ls_ot_i, cl: ls_cl_i, ol: ls_ol_i};

    assign ov_shut = sup_f.ov & hvse_i & (mode == MODE_NORMAL);

    fih_sticky_reg #(.W(4)) u_sup_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (sup_f),
        .rd_i  (rd_sup_i),
        .q_o   (sup_stat_o)
    );

    fih_sticky_reg #(.W(STAT_W)) u_hs_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (drv_stat(hs_f)),
        .rd_i  (rd_hs_i),
        .q_o   (hs_stat_o)
    );

    fih_sticky_reg #(.W(STAT_W)) u_ls_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (drv_stat(ls_f)),
        .rd_i  (rd_ls_i),
        .q_o   (ls_stat_o)
    );

    fih_drv_gate #(.N(DRV_N)) u_hs_gate (
        .clk    (clk),
        .rst    (rst),
        .shut_i (hs_f.ot | ov_shut),
        .wr_i   (wr_hs_i),
        .wr_d_i (wr_hs_d_i),
        .en_o   (hs_en_o)
    );

    fih_drv_gate #(.N(DRV_N)) u_ls_gate (
        .clk    (clk),
        .rst    (rst),
        .shut_i (ls_f.ot | ov_shut),
        .wr_i   (wr_ls_i),
        .wr_d_i (wr_ls_d_i),
        .en_o   (ls_en_o)
    );

    always_comb begin
        req[SRC_HS]   = drv_any(hs_f);
        req[SRC_LS]   = drv_any(ls_f);
        req[SRC_SUP]  = sup_f.uv | sup_f.ov;
        mask[SRC_HS]  = mask_hs_i;
        mask[SRC_LS]  = mask_ls_i;
        mask[SRC_SUP] = mask_sup_i;
        clr[SRC_HS]   = rd_hs_i;
        clr[SRC_LS]   = rd_ls_i;
        clr[SRC_SUP]  = rd_sup_i;
    end

    fih_irq_arb #(.NSRC(SRC_N), .CW(CODE_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .allow_i (irq_mode_ok(mode)),
        .req_i   (req),
        .mask_i  (mask),
        .clr_i   (clr),
        .code_o  (isr_code_o),
        .irq_n_o (irq_n_o)
    );

endmodule

// File: rtl/fih_chk.sv
module fih_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_i,
    input logic       hvse_i,
    input logic       sup_ov_i,
    input logic       hs_ot_i,
    input logic [1:0] hs_cl_i,
    input logic [1:0] hs_ol_i,
    input logic       ls_ot_i,
    input logic       mask_sup_i,
    input logic       mask_hs_i,
    input logic       mask_ls_i,
    input logic       rd_hs_i,
    input logic       wr_hs_i,
    input logic [3:0] hs_stat_o,
    input logic [3:0] ls_stat_o,
    input logic [3:0] isr_code_o,
    input logic       irq_n_o,
    input logic [1:0] hs_en_o,
    input logic [1:0] ls_en_o
);

    // R3
    hs_thermal_off_chk: assert property (@(posedge clk) disable iff (rst)
        hs_ot_i |=> (hs_en_o == 2'b00) && (hs_stat_o == 4'hF));

    // R3
    ls_thermal_off_chk: assert property (@(posedge clk) disable iff (rst)
        ls_ot_i |=> (ls_en_o == 2'b00) && (ls_stat_o == 4'hF));

    // R4
    ov_group_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sup_ov_i && hvse_i && mode_i == 2'd0) |=> (hs_en_o == 2'b00) && (ls_en_o == 2'b00));

    // R5
    limit_keeps_on_chk: assert property (@(posedge clk) disable iff (rst)
        ((hs_cl_i != 2'b00 || hs_ol_i != 2'b00) && !hs_ot_i && !wr_hs_i
         && !(sup_ov_i && hvse_i && mode_i == 2'd0)) |=> $stable(hs_en_o));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_stat_o[0] && !rd_hs_i) |=> hs_stat_o[0]);

    // R7
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        isr_code_o inside {4'b0000, 4'b0010, 4'b0011, 4'b0101});

    // R7
    irq_code_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq_n_o == (isr_code_o == 4'b0000));

    // R9
    quiet_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd3 && irq_n_o) |=> irq_n_o);

    // R10
    masked_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_sup_i && mask_hs_i && mask_ls_i && irq_n_o) |=> irq_n_o);

endmodule

bind fault_irq_hub fih_chk u_fih_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .hvse_i     (hvse_i),
    .sup_ov_i   (sup_ov_i),
    .hs_ot_i    (hs_ot_i),
    .hs_cl_i    (hs_cl_i),
    .hs_ol_i    (hs_ol_i),
    .ls_ot_i    (ls_ot_i),
    .mask_sup_i (mask_sup_i),
    .mask_hs_i  (mask_hs_i),
    .mask_ls_i  (mask_ls_i),
    .rd_hs_i    (rd_hs_i),
    .wr_hs_i    (wr_hs_i),
    .hs_stat_o  (hs_stat_o),
    .ls_stat_o  (ls_stat_o),
    .isr_code_o (isr_code_o),
    .irq_n_o    (irq_n_o),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o)
);

// File: tb/fault_irq_hub_bench.sv
`timescale 1ns/1ps
module fault_irq_hub_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic hvse_i = 0, sup_bf_i = 0, sup_otw_i = 0, sup_uv_i = 0, sup_ov_i = 0;
    logic hs_ot_i = 0, ls_ot_i = 0;
    logic [1:0] hs_cl_i = 0, hs_ol_i = 0, ls_cl_i = 0, ls_ol_i = 0;
    logic mask_sup_i = 0, mask_hs_i = 0, mask_ls_i = 0;
    logic rd_sup_i = 0, rd_hs_i = 0, rd_ls_i = 0;
    logic wr_hs_i = 0, wr_ls_i = 0;
    logic [1:0] wr_hs_d_i = 0, wr_ls_d_i = 0;
    logic [3:0] sup_stat_o, hs_stat_o, ls_stat_o, isr_code_o;
    logic irq_n_o;
    logic [1:0] hs_en_o, ls_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state
    logic [3:0] m_sup, m_hs, m_ls;
    logic [2:0] m_pend;
    logic [1:0] m_hsen, m_lsen;

    always #2 clk = ~clk;

    fault_irq_hub u_fault_irq_hub (
        .clk(clk), .rst(rst), .mode_i(mode_i), .hvse_i(hvse_i),
        .sup_bf_i(sup_bf_i), .sup_otw_i(sup_otw_i), .sup_uv_i(sup_uv_i), .sup_ov_i(sup_ov_i),
        .hs_ot_i(hs_ot_i), .hs_cl_i(hs_cl_i), .hs_ol_i(hs_ol_i),
        .ls_ot_i(ls_ot_i), .ls_cl_i(ls_cl_i), .ls_ol_i(ls_ol_i),
        .mask_sup_i(mask_sup_i), .mask_hs_i(mask_hs_i), .mask_ls_i(mask_ls_i),
        .rd_sup_i(rd_sup_i), .rd_hs_i(rd_hs_i), .rd_ls_i(rd_ls_i),
        .wr_hs_i(wr_hs_i), .wr_hs_d_i(wr_hs_d_i), .wr_ls_i(wr_ls_i), .wr_ls_d_i(wr_ls_d_i),
        .sup_stat_o(sup_stat_o), .hs_stat_o(hs_stat_o), .ls_stat_o(ls_stat_o),
        .isr_code_o(isr_code_o), .irq_n_o(irq_n_o), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
    );

    function automatic logic [3:0] grp_bits(logic ot, logic [1:0] cl, logic [1:0] ol);
        return ot ? 4'hF : {ol[1], cl[1], ol[0], cl[0]};
    endfunction

    function automatic logic [3:0] exp_code(logic [2:0] p);
        if (p[0]) return 4'b0010;
        if (p[1]) return 4'b0011;
        if (p[2]) return 4'b0101;
        return 4'b0000;
    endfunction

    task automatic model_step();
        logic allow, shut_ov;
        if (rst) begin
            m_sup = 0; m_hs = 0; m_ls = 0; m_pend = 0; m_hsen = 0; m_lsen = 0;
            return;
        end
        allow   = (mode_i != 2'd3);
        shut_ov = sup_ov_i & hvse_i & (mode_i == 2'd0);
        m_sup = (m_sup & ~{4{rd_sup_i}}) | {sup_ov_i, sup_uv_i, sup_otw_i, sup_bf_i};
        m_hs  = (m_hs & ~{4{rd_hs_i}}) | grp_bits(hs_ot_i, hs_cl_i, hs_ol_i);
        m_ls  = (m_ls & ~{4{rd_ls_i}}) | grp_bits(ls_ot_i, ls_cl_i, ls_ol_i);
        m_pend[0] = (m_pend[0] & ~rd_hs_i) |
                    ((hs_ot_i | (|hs_cl_i) | (|hs_ol_i)) & allow & ~mask_hs_i);
        m_pend[1] = (m_pend[1] & ~rd_ls_i) |
                    ((ls_ot_i | (|ls_cl_i) | (|ls_ol_i)) & allow & ~mask_ls_i);
        m_pend[2] = (m_pend[2] & ~rd_sup_i) | ((sup_uv_i | sup_ov_i) & allow & ~mask_sup_i);
        if (hs_ot_i | shut_ov) m_hsen = 0; else if (wr_hs_i) m_hsen = wr_hs_d_i;
        if (ls_ot_i | shut_ov) m_lsen = 0; else if (wr_ls_i) m_lsen = wr_ls_d_i;
    endtask

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one rising edge, then sample on the falling edge
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic cmp_model();
        chk("R1 sup_stat", sup_stat_o, m_sup);
        chk("R2 hs_stat", hs_stat_o, m_hs);
        chk("R2 ls_stat", ls_stat_o, m_ls);
        chk("R8 code", isr_code_o, exp_code(m_pend));
        chk("R7 irq_n", {3'b0, irq_n_o}, {3'b0, ~(|m_pend)});
        chk("R11 hs_en", {2'b0, hs_en_o}, {2'b0, m_hsen});
        chk("R11 ls_en", {2'b0, ls_en_o}, {2'b0, m_lsen});
    endtask

    task automatic quiet_inputs();
        sup_bf_i = 0; sup_otw_i = 0; sup_uv_i = 0; sup_ov_i = 0;
        hs_ot_i = 0; ls_ot_i = 0; hs_cl_i = 0; hs_ol_i = 0; ls_cl_i = 0; ls_ol_i = 0;
        rd_sup_i = 0; rd_hs_i = 0; rd_ls_i = 0; wr_hs_i = 0; wr_ls_i = 0;
        mask_sup_i = 0; mask_hs_i = 0; mask_ls_i = 0; hvse_i = 0; mode_i = 0;
    endtask

    task automatic do_reset();
        quiet_inputs();
        rst = 1; cycle(); cycle(); rst = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R12 reset state
        chk("R12 sup_stat", sup_stat_o, 0);
        chk("R12 hs_stat", hs_stat_o, 0);
        chk("R12 ls_stat", ls_stat_o, 0);
        chk("R12 code", isr_code_o, 0);
        chk("R12 irq_n", {3'b0, irq_n_o}, 4'd1);
        chk("R12 en", {hs_en_o, ls_en_o}, 4'h0);

        // R11 enable writes
        wr_hs_i = 1; wr_hs_d_i = 2'b11; wr_ls_i = 1; wr_ls_d_i = 2'b11; cycle();
        wr_hs_i = 0; wr_ls_i = 0;
        chk("R11 en after write", {hs_en_o, ls_en_o}, 4'hF);

        // R5, R2, R7 current limit on HS channel 0
        hs_cl_i = 2'b01; cycle(); hs_cl_i = 0;
        chk("R2 hs cl0 bit", hs_stat_o, 4'b0001);
        chk("R5 hs stays on", {2'b0, hs_en_o}, 4'd3);
        chk("R7 hs code", isr_code_o, 4'b0010);
        chk("R7 irq low", {3'b0, irq_n_o}, 4'd0);
        rd_hs_i = 1; cycle(); rd_hs_i = 0;
        chk("R6 cleared by read", hs_stat_o, 0);
        chk("R8 irq high after read", {3'b0, irq_n_o}, 4'd1);

        // R8 priority: LS and supply both pending
        ls_ol_i = 2'b10; sup_uv_i = 1; cycle(); ls_ol_i = 0; sup_uv_i = 0;
        chk("R2 ls ol1 bit", ls_stat_o, 4'b1000);
        chk("R1 uv bit", sup_stat_o, 4'b0100);
        chk("R8 lowest code first", isr_code_o, 4'b0011);
        rd_ls_i = 1; cycle(); rd_ls_i = 0;
        chk("R8 next source", isr_code_o, 4'b0101);
        rd_sup_i = 1; cycle(); rd_sup_i = 0;
        chk("R8 all read code", isr_code_o, 0);
        chk("R8 all read irq", {3'b0, irq_n_o}, 4'd1);

        // R6 read while condition present
        hs_ol_i = 2'b10; cycle(); rd_hs_i = 1; cycle(); rd_hs_i = 0;
        chk("R6 held while present", hs_stat_o, 4'b1000);
        hs_ol_i = 0; rd_hs_i = 1; cycle(); rd_hs_i = 0;
        chk("R6 clear once gone", hs_stat_o, 0);

        // R3 thermal shutdown of HS
        hs_ot_i = 1; cycle();
        chk("R3 hs all flags", hs_stat_o, 4'hF);
        chk("R3 hs off", {2'b0, hs_en_o}, 0);
        chk("R3 ls untouched", {2'b0, ls_en_o}, 4'd3);
        wr_hs_i = 1; wr_hs_d_i = 2'b11; cycle();
        chk("R3 write ignored while hot", {2'b0, hs_en_o}, 0);
        hs_ot_i = 0; cycle(); wr_hs_i = 0;
        chk("R3 re-enabled by write", {2'b0, hs_en_o}, 4'd3);
        ls_ot_i = 1; cycle(); ls_ot_i = 0;
        chk("R3 ls all flags", ls_stat_o, 4'hF);
        chk("R3 ls off", {2'b0, ls_en_o}, 0);
        wr_ls_i = 1; wr_ls_d_i = 2'b11; cycle(); wr_ls_i = 0;

        // R4 over-voltage shutdown
        hvse_i = 1; mode_i = 2'd1; sup_ov_i = 1; cycle();
        chk("R4 no shutdown outside Normal", {hs_en_o, ls_en_o}, 4'hF);
        mode_i = 2'd0; cycle();
        chk("R4 shutdown in Normal", {hs_en_o, ls_en_o}, 4'h0);
        chk("R1 ov bit", sup_stat_o & 4'b1000, 4'b1000);
        hvse_i = 0; wr_hs_i = 1; wr_ls_i = 1; cycle(); wr_hs_i = 0; wr_ls_i = 0;
        cycle();
        chk("R4 no shutdown with hvse 0", {hs_en_o, ls_en_o}, 4'hF);
        sup_ov_i = 0;

        // R9 low-power mode
        do_reset();
        mode_i = 2'd3; sup_uv_i = 1; sup_bf_i = 1; sup_otw_i = 1; cycle();
        sup_uv_i = 0; sup_bf_i = 0; sup_otw_i = 0;
        chk("R1 uv bf otw bits", sup_stat_o, 4'b0111);
        chk("R9 no irq in mode 3", {3'b0, irq_n_o}, 4'd1);
        mode_i = 2'd2; hs_cl_i = 2'b10; cycle(); hs_cl_i = 0;
        chk("R9 irq in Stop", isr_code_o, 4'b0010);

        // R10 masking
        do_reset();
        mask_ls_i = 1; ls_cl_i = 2'b01; cycle(); ls_cl_i = 0;
        chk("R10 masked flag latches", ls_stat_o, 4'b0001);
        chk("R10 masked no irq", {3'b0, irq_n_o}, 4'd1);
        mask_sup_i = 1; sup_ov_i = 1; hs_ol_i = 2'b01; cycle(); sup_ov_i = 0; hs_ol_i = 0;
        chk("R10 unmasked still reported", isr_code_o, 4'b0010);

        // randomized phase against model
        do_reset();
        void'($urandom(32'd4242));
        for (int n = 0; n < 600; n++) begin
            mode_i    = 2'($urandom_range(0, 3));
            hvse_i    = ($urandom_range(0, 3) == 0);
            sup_bf_i  = ($urandom_range(0, 15) == 0);
            sup_otw_i = ($urandom_range(0, 15) == 0);
            sup_uv_i  = ($urandom_range(0, 9) == 0);
            sup_ov_i  = ($urandom_range(0, 9) == 0);
            hs_ot_i   = ($urandom_range(0, 19) == 0);
            ls_ot_i   = ($urandom_range(0, 19) == 0);
            hs_cl_i   = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            hs_ol_i   = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            ls_cl_i   = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            ls_ol_i   = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            if ($urandom_range(0, 31) == 0) begin
                mask_sup_i = 1'($urandom); mask_hs_i = 1'($urandom); mask_ls_i = 1'($urandom);
            end
            rd_sup_i  = ($urandom_range(0, 3) == 0);
            rd_hs_i   = ($urandom_range(0, 3) == 0);
            rd_ls_i   = ($urandom_range(0, 3) == 0);
            wr_hs_i   = ($urandom_range(0, 5) == 0);
            wr_ls_i   = ($urandom_range(0, 5) == 0);
            wr_hs_d_i = 2'($urandom);
            wr_ls_d_i = 2'($urandom);
            cycle();
            cmp_model();
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule